// File: doc/BRIEF.md
# Selectable 10-bit Test Word Generator

This block produces one 10-bit transmit code word on each rising edge of a 125 MHz reference clock, for feeding a gigabit serializer during bench evaluation. A 2-bit mode input picks the pattern. The available patterns are a continuous PRBS7 stream, a constant word, K28.5 comma characters that alternate between their two disparity forms, and an idle mode that sends all zeros.

A manual-override input lets a static 10-bit word take the place of the generated pattern. While the override is active, the pattern state does not move. When the override is released, the PRBS stream or the comma alternation resumes from where it stopped.

All generated values are complete 10b code words, and bit 0 of the output is the first bit to be serialized. The output is registered, so each word appears one clock after the inputs that select it.

Top module: `tpg10_top`

## Requirements
- R1: `tx_word` is a register. The value selected by the inputs sampled at a rising edge appears on `tx_word` just after that same edge, and a new word is produced on every edge.
- R2: With `mode_sel` = 2'b00 and `manual_en` low, `tx_word` is 10'h000.
- R3: With `mode_sel` = 2'b01 and `manual_en` low, `tx_word` carries a PRBS7 sequence (x^7+x^6+1).
  - The 7-bit state starts at 7'h7F.
  - Each word takes 10 successive generator steps. Each step computes the bit state[6]^state[5] and then sets state = {state[5:0], bit}.
  - The bit from the first step goes to `tx_word[0]`, so the concatenated words form one unbroken PRBS7 stream.
- R4: With `mode_sel` = 2'b10 and `manual_en` low, `tx_word` is 10'h0F0 on every cycle. That is, bits [9:2] are 00111100 and bits [1:0] are 00.
- R5: With `mode_sel` = 2'b11 and `manual_en` low, `tx_word` alternates on each cycle between 10'h17C (K28.5, negative disparity, bit a at bit 0) and 10'h283 (K28.5, positive disparity). The first comma after reset is 10'h17C.
- R6: While `manual_en` is high, `tx_word` equals the `manual_word` sampled at the same edge, whatever the value of `mode_sel`.
- R7: While `manual_en` is high, neither the PRBS state nor the comma disparity changes. After release, the PRBS stream and the comma alternation continue from the point where they stopped.
- R8: The PRBS state moves only on cycles spent in PRBS mode. The comma disparity flips only on cycles spent in comma mode. Time spent in any other mode leaves both unchanged.
- R9: A synchronous active-low reset does three things: it sets `tx_word` to 10'h000, reloads the PRBS seed 7'h7F, and makes the next comma the negative-disparity form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz reference clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | Pattern select: 00 idle, 01 PRBS7, 10 constant word, 11 alternating K28.5 |
| manual_en | input | 1 | High selects the manual word in place of the pattern |
| manual_word | input | 10 | Static word sent while `manual_en` is high |
| tx_word | output | 10 | Registered transmit code word, bit 0 serialized first |

## Verification
The assertions assume that `mode_sel`, `manual_en` and `manual_word` are stable around each rising edge and are never X once reset is released. The comma alternation check also assumes that comma mode is held for at least two consecutive cycles before it compares words. The stimulus changes inputs only on falling edges and drives every input with a defined value from time zero. It holds each mode for a run of several cycles, so that the assumptions stay true while mode switches, manual override windows and a mid-run reset are all exercised.

// File: rtl/tpg10_pkg.sv
// Package tpg10_pkg
// Shared mode encoding and word constants for the 10-bit test word
// generator. Assumes a 10-bit code word with bit 0 serialized first.
package tpg10_pkg;

    localparam int TPG_WORD_W = 10;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_PRBS  = 2'b01,
        MODE_FIXED = 2'b10,
        MODE_COMMA = 2'b11
    } tpg_mode_e;

    localparam logic [TPG_WORD_W-1:0] COMMA_NEG_WORD = 10'h17C;
    localparam logic [TPG_WORD_W-1:0] COMMA_POS_WORD = 10'h283;
    localparam logic [TPG_WORD_W-1:0] FIXED_WORD_DEF = 10'h0F0;
    localparam logic [TPG_WORD_W-1:0] IDLE_WORD      = '0;

endpackage

// File: rtl/tpg10_prbs_gen.sv
// Module tpg10_prbs_gen
// Fibonacci LFSR that presents the next WORD_W bits of its sequence as a
// parallel word and advances by WORD_W steps when adv is high.
// Assumes: SEED is nonzero and the tap positions give a maximal-length
// polynomial. The first generated bit lands in word[0].
module tpg10_prbs_gen #(
    parameter int                LFSR_W = 7,
    parameter int                WORD_W = 10,
    parameter int                TAP_HI = 7,
    parameter int                TAP_LO = 6,
    parameter logic [LFSR_W-1:0] SEED   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [WORD_W-1:0] word
);

    localparam int HI_IDX = TAP_HI - 1;
    localparam int LO_IDX = TAP_LO - 1;

    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] state_next;

    // Unroll WORD_W generator steps from the present state.
    always_comb begin
        logic [LFSR_W-1:0] s;
        logic              fb;
        s    = state_q;
        word = '0;
        for (int i = 0; i < WORD_W; i++) begin
            fb      = s[HI_IDX] ^ s[LO_IDX];
            word[i] = fb;
            s       = {s[LFSR_W-2:0], fb};
        end
        state_next = s;
    end

    // Hold or advance the LFSR state one full word at a time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEED;
        else if (adv)
            state_q <= state_next;
    end

    // The LFSR must never fall into the all-zero lock-up state.
    p_lfsr_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // The state is frozen on any cycle without an advance request.
    p_lfsr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state_q));

endmodule

// File: rtl/tpg10_comma_gen.sv
// Module tpg10_comma_gen
// Tracks running disparity for the comma pattern and presents the K28.5
// form that matches it. Flips the disparity each time adv is high.
// Assumes: reset leaves the disparity negative, so the first comma is
// the negative-disparity form.
module tpg10_comma_gen
    import tpg10_pkg::*;
#(
    parameter int WORD_W = TPG_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [WORD_W-1:0] word
);

    logic neg_q;

    // Flip the running disparity after each emitted comma.
    always_ff @(posedge clk) begin
        if (!rst_n)
            neg_q <= 1'b1;
        else if (adv)
            neg_q <= ~neg_q;
    end

    // Pick the comma form that matches the present disparity.
    always_comb begin
        word = neg_q ? COMMA_NEG_WORD : COMMA_POS_WORD;
    end

    // Disparity holds while comma mode is not driving the output.
    p_disp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(neg_q));

endmodule

// File: rtl/tpg10_top.sv
// Module tpg10_top
// Selectable 10-bit test word generator. The mode select picks idle,
// PRBS7, a constant word or alternating K28.5. A manual override takes
// the place of the pattern and freezes the pattern state.
// Assumes: inputs are synchronous to clk. Reset is synchronous and
// active low.
module tpg10_top
    import tpg10_pkg::*;
#(
    parameter int                    WORD_W     = TPG_WORD_W,
    parameter int                    LFSR_W     = 7,
    parameter logic [LFSR_W-1:0]     PRBS_SEED  = 7'h7F,
    parameter logic [WORD_W-1:0]     FIXED_WORD = FIXED_WORD_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              manual_en,
    input  logic [WORD_W-1:0] manual_word,
    output logic [WORD_W-1:0] tx_word
);

    tpg_mode_e         mode;
    logic              prbs_adv;
    logic              comma_adv;
    logic [WORD_W-1:0] prbs_word;
    logic [WORD_W-1:0] comma_word;
    logic [WORD_W-1:0] gen_word;

    // Decode the mode and decide which pattern state may move.
    always_comb begin
        mode      = tpg_mode_e'(mode_sel);
        prbs_adv  = !manual_en && (mode == MODE_PRBS);
        comma_adv = !manual_en && (mode == MODE_COMMA);
    end

    tpg10_prbs_gen #(
        .LFSR_W (LFSR_W),
        .WORD_W (WORD_W),
        .TAP_HI (7),
        .TAP_LO (6),
        .SEED   (PRBS_SEED)
    ) u_prbs (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (prbs_adv),
        .word  (prbs_word)
    );

    tpg10_comma_gen #(
        .WORD_W (WORD_W)
    ) u_comma (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (comma_adv),
        .word  (comma_word)
    );

    // Select the pattern word for the present mode.
    always_comb begin
        unique case (mode)
            MODE_PRBS:  gen_word = prbs_word;
            MODE_FIXED: gen_word = FIXED_WORD;
            MODE_COMMA: gen_word = comma_word;
            default:    gen_word = IDLE_WORD;
        endcase
    end

    // Output register: the manual word overrides the pattern.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_word <= '0;
        else if (manual_en)
            tx_word <= manual_word;
        else
            tx_word <= gen_word;
    end

    // Idle mode sends zeros one cycle later.
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00 && !manual_en) |=> tx_word == '0);

    // Constant mode sends the fixed word one cycle later.
    p_fixed_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10 && !manual_en) |=> tx_word == FIXED_WORD);

    // Comma mode only ever emits one of the two K28.5 forms.
    p_comma_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11 && !manual_en) |=>
            (tx_word == COMMA_NEG_WORD || tx_word == COMMA_POS_WORD));

    // Back-to-back commas change form on every cycle.
    p_comma_alt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11 && !manual_en && $past(mode_sel == 2'b11 && !manual_en))
            |=> tx_word != $past(tx_word));

    // Manual override reaches the output one cycle later.
    p_manual_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        manual_en |=> tx_word == $past(manual_word));

endmodule

// File: tb/tpg10_top_tb.sv
// Bench for tpg10_top. A behavioural reference model is stepped once per
// clock and compared against the output on every falling edge.
module tpg10_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b11;
    logic       manual_en = 1'b0;
    logic [9:0] manual_word = '0;
    logic [9:0] tx_word;

    int checks = 0;
    int fails  = 0;

    // Reference model state.
    int          m_lfsr = 7'h7F;
    bit          m_neg  = 1'b1;
    logic [9:0]  m_exp  = '0;

    tpg10_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_sel    (mode_sel),
        .manual_en   (manual_en),
        .manual_word (manual_word),
        .tx_word     (tx_word)
    );

    always #4 clk = ~clk;

    // One cycle: drive, let the edge pass, update the model, compare (R1).
    task automatic step(input logic [1:0] m, input logic men,
                        input logic [9:0] mw, input logic rn, input string tag);
        mode_sel    = m;
        manual_en   = men;
        manual_word = mw;
        rst_n       = rn;
        @(posedge clk);
        if (!rn) begin
            m_exp  = '0;
            m_lfsr = 7'h7F;
            m_neg  = 1'b1;
        end else if (men) begin
            m_exp = mw;
        end else begin
            case (m)
                2'b01: begin
                    m_exp = '0;
                    for (int i = 0; i < 10; i++) begin
                        int b;
                        b = ((m_lfsr >> 6) ^ (m_lfsr >> 5)) & 1;
                        m_exp[i] = b[0];
                        m_lfsr = ((m_lfsr << 1) | b) & 127;
                    end
                end
                2'b10: m_exp = 10'h0F0;
                2'b11: begin
                    m_exp = m_neg ? 10'h17C : 10'h283;
                    m_neg = !m_neg;
                end
                default: m_exp = '0;
            endcase
        end
        @(negedge clk);
        checks++;
        if (tx_word !== m_exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, tx_word, m_exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R9: reset state, zero output while reset is held.
        repeat (3) step(2'b11, 1'b0, 10'h000, 1'b0, "R9");
        // R5: comma alternation starting on the negative form.
        repeat (6) step(2'b11, 1'b0, 10'h000, 1'b1, "R5");
        // R3: PRBS7 stream.
        repeat (20) step(2'b01, 1'b0, 10'h000, 1'b1, "R3");
        // R4: constant word.
        repeat (5) step(2'b10, 1'b0, 10'h000, 1'b1, "R4");
        // R2: idle zeros.
        repeat (4) step(2'b00, 1'b0, 10'h000, 1'b1, "R2");
        // R7: comma disparity frozen across an override.
        repeat (3) step(2'b11, 1'b0, 10'h000, 1'b1, "R5");
        step(2'b11, 1'b1, 10'h3FF, 1'b1, "R6");
        step(2'b01, 1'b1, 10'h155, 1'b1, "R6");
        step(2'b00, 1'b1, 10'h2AA, 1'b1, "R6");
        step(2'b10, 1'b1, 10'h001, 1'b1, "R6");
        repeat (3) step(2'b11, 1'b0, 10'h000, 1'b1, "R7");
        // R7: PRBS frozen across an override.
        repeat (5) step(2'b01, 1'b0, 10'h000, 1'b1, "R3");
        repeat (3) step(2'b01, 1'b1, 10'h0C3, 1'b1, "R6");
        repeat (5) step(2'b01, 1'b0, 10'h000, 1'b1, "R7");
        // R8: other modes leave PRBS and disparity untouched.
        repeat (3) step(2'b01, 1'b0, 10'h000, 1'b1, "R3");
        repeat (3) step(2'b10, 1'b0, 10'h000, 1'b1, "R4");
        repeat (3) step(2'b01, 1'b0, 10'h000, 1'b1, "R8");
        step(2'b11, 1'b0, 10'h000, 1'b1, "R5");
        repeat (2) step(2'b00, 1'b0, 10'h000, 1'b1, "R2");
        repeat (3) step(2'b11, 1'b0, 10'h000, 1'b1, "R8");
        // R9: mid-run reset reloads seed and disparity.
        repeat (2) step(2'b01, 1'b0, 10'h000, 1'b0, "R9");
        repeat (5) step(2'b01, 1'b0, 10'h000, 1'b1, "R9");
        step(2'b11, 1'b0, 10'h000, 1'b0, "R9");
        repeat (3) step(2'b11, 1'b0, 10'h000, 1'b1, "R9");
        // R6: override held while reset is low loses to reset.
        step(2'b10, 1'b1, 10'h3C3, 1'b0, "R9");
        step(2'b10, 1'b1, 10'h3C3, 1'b1, "R6");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule